// File: doc/BRIEF.md
# Performance Cycle Counter with Divider

This block keeps a clock-cycle count for performance monitoring. Software sets it up through a 32-bit control register and can read or load the count register directly. Each cycle in which the `tick` input is high is one elapsed core clock. When the block is enabled, the count advances on every such tick. In divided mode it advances once for every 64 ticks, and a prescaler keeps the ticks left over between advances.

When the count passes its all-ones value it returns to zero and sets an overflow flag in the control register. If the overflow interrupt is enabled, a level-sensitive request is raised. The `routeFast` input, which carries the steering bit kept in a separate register, sends that request to the fast line or to the normal line. The request stays asserted until software clears the flag.

Top module: `pmc_cycle_counter`

## Requirements
- R1: After reset the control register reads 0, the count reads 0, and both interrupt lines are low.
- R2: Control writes keep only the bits under mask 0x0FFFF77F. Bit 2 is never stored. All other bits read 0, so writing 0xFFFFFFFF to a cleared register reads back 0x0FFFF07B.
- R3: While control bit 0 (enable) is 0, ticks do not change the count.
- R4: With enable set and control bit 3 (divide) clear, the count rises by exactly one for each cycle in which `tick` is high.
- R5: With enable and divide both set, the count rises once per 64 ticks, whether the ticks are back to back or spaced apart.
- R6: A control write with bit 2 set clears the count to 0 at that clock edge. Bit 2 then reads back as 0.
- R7: The prescaler returns to zero on a clear command, on any write that changes the divide bit, and while enable is 0. After any of these, a full 64 further ticks are needed for the next divided advance.
- R8: An advance from 0xFFFFFFFF gives 0 and sets control bit 10 (the overflow flag).
- R9: A control write with bit 10 set clears the overflow flag. A write with bit 10 clear leaves the flag unchanged. A wrap in the same cycle as such a write leaves the flag set.
- R10: While bit 10 and bit 6 (the overflow interrupt enable) are both set, `fiqReq` is high if `routeFast` is 1 and `irqReq` is high otherwise. Both lines are low when either bit is clear, and they are never high together.
- R11: A count-register write loads `cntWrData` at that edge. It takes priority over a clear command and over an advance in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rstN | input | 1 | Active-low asynchronous reset |
| tick | input | 1 | One elapsed clock cycle to be counted |
| ctrlWrEn | input | 1 | Control register write strobe |
| ctrlWrData | input | 32 | Control register write data |
| cntWrEn | input | 1 | Count register write strobe |
| cntWrData | input | CNT_W | Count register write data |
| routeFast | input | 1 | Steering bit: 1 selects the fast interrupt line |
| ctrlRdData | output | 32 | Control register contents |
| cntRdData | output | CNT_W | Current count |
| irqReq | output | 1 | Normal interrupt request |
| fiqReq | output | 1 | Fast interrupt request |

## Verification
The properties assume that every input is a known value at each rising edge. They also assume that a write strobe describes a single edge's command, with no meaning carried between cycles. Properties about advancing the count exclude cycles that carry a control write or a count write, because those writes outrank or change the count. The stimulus changes inputs only on falling edges. It raises each strobe for exactly one cycle, and it holds `tick` low during register writes unless a test is about collisions on purpose.

// File: rtl/pmc_pkg.sv
package pmc_pkg;
  localparam int CTRL_W   = 32;
  localparam int EN_BIT   = 0;
  localparam int CLR_BIT  = 2;
  localparam int DIV_BIT  = 3;
  localparam int OVIE_BIT = 6;
  localparam int OVF_BIT  = 10;
  localparam logic [CTRL_W-1:0] WR_MASK   = 32'h0FFF_F77F;
  localparam logic [CTRL_W-1:0] FLAG_MASK = 32'h0000_0700;
  localparam logic [CTRL_W-1:0] CLR_MASK  = 32'h0000_0004;

  typedef struct packed {
    logic incr;
    logic clear;
  } cntStrobe_t;
endpackage

// File: rtl/pmc_ctrl.sv
module pmc_ctrl
  import pmc_pkg::*;
#(
  parameter int PRE_W = 6
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              tick,
  input  logic              ctrlWrEn,
  input  logic [CTRL_W-1:0] ctrlWrData,
  input  logic              wrapPulse,
  output logic [CTRL_W-1:0] ctrlQ,
  output cntStrobe_t        strobe
);
  logic [PRE_W-1:0]  preQ, preNext;
  logic [CTRL_W-1:0] baseNext, flagsNext;
  logic enable, divMode, clrCmd, divChange, preFull;

  always_comb begin
    enable    = ctrlQ[EN_BIT];
    divMode   = ctrlQ[DIV_BIT];
    clrCmd    = ctrlWrEn & ctrlWrData[CLR_BIT];
    divChange = ctrlWrEn & (ctrlWrData[DIV_BIT] != divMode);
    preFull   = &preQ;
    strobe.clear = clrCmd;
    strobe.incr  = enable & tick & (~divMode | preFull);
  end

  // Remainder of ticks between divided advances
  always_comb begin
    if (!enable || clrCmd || divChange) preNext = '0;
    else if (tick && divMode)           preNext = preQ + 1'b1;
    else                                preNext = preQ;
  end

  // Stored fields plus write-one-to-clear flags
  always_comb begin
    baseNext  = ctrlQ & ~FLAG_MASK;
    flagsNext = ctrlQ & FLAG_MASK;
    if (ctrlWrEn) begin
      baseNext  = ctrlWrData & WR_MASK & ~FLAG_MASK & ~CLR_MASK;
      flagsNext = flagsNext & ~(ctrlWrData & FLAG_MASK);
    end
    if (wrapPulse) flagsNext[OVF_BIT] = 1'b1;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      ctrlQ <= '0;
      preQ  <= '0;
    end else begin
      ctrlQ <= baseNext | flagsNext;
      preQ  <= preNext;
    end
  end
endmodule

// File: rtl/pmc_count.sv
module pmc_count
  import pmc_pkg::*;
#(
  parameter int CNT_W = 32
) (
  input  logic             clk,
  input  logic             rstN,
  input  cntStrobe_t       strobe,
  input  logic             cntWrEn,
  input  logic [CNT_W-1:0] cntWrData,
  output logic [CNT_W-1:0] cntQ,
  output logic             wrapPulse
);
  assign wrapPulse = strobe.incr & (&cntQ) & ~cntWrEn & ~strobe.clear;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)             cntQ <= '0;
    else if (cntWrEn)      cntQ <= cntWrData;
    else if (strobe.clear) cntQ <= '0;
    else if (strobe.incr)  cntQ <= cntQ + 1'b1;
  end
endmodule

// File: rtl/pmc_cycle_counter.sv
module pmc_cycle_counter
  import pmc_pkg::*;
#(
  parameter int CNT_W = 32,
  parameter int PRE_W = 6
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              tick,
  input  logic              ctrlWrEn,
  input  logic [CTRL_W-1:0] ctrlWrData,
  input  logic              cntWrEn,
  input  logic [CNT_W-1:0]  cntWrData,
  input  logic              routeFast,
  output logic [CTRL_W-1:0] ctrlRdData,
  output logic [CNT_W-1:0]  cntRdData,
  output logic              irqReq,
  output logic              fiqReq
);
  cntStrobe_t strobe;
  logic       wrapPulse;
  logic       ovfActive;

  pmc_ctrl #(.PRE_W(PRE_W)) ctrl_i (
    .clk(clk), .rstN(rstN), .tick(tick),
    .ctrlWrEn(ctrlWrEn), .ctrlWrData(ctrlWrData),
    .wrapPulse(wrapPulse), .ctrlQ(ctrlRdData), .strobe(strobe)
  );

  pmc_count #(.CNT_W(CNT_W)) count_i (
    .clk(clk), .rstN(rstN), .strobe(strobe),
    .cntWrEn(cntWrEn), .cntWrData(cntWrData),
    .cntQ(cntRdData), .wrapPulse(wrapPulse)
  );

  assign ovfActive = ctrlRdData[OVF_BIT] & ctrlRdData[OVIE_BIT];
  assign fiqReq    = ovfActive & routeFast;
  assign irqReq    = ovfActive & ~routeFast;
endmodule

// File: rtl/pmc_cycle_counter_chk.sv
module pmc_cycle_counter_chk
  import pmc_pkg::*;
#(
  parameter int CNT_W = 32
) (
  input logic              clk,
  input logic              rstN,
  input logic              tick,
  input logic              ctrlWrEn,
  input logic [CTRL_W-1:0] ctrlWrData,
  input logic              cntWrEn,
  input logic [CNT_W-1:0]  cntWrData,
  input logic              routeFast,
  input logic [CTRL_W-1:0] ctrlRdData,
  input logic [CNT_W-1:0]  cntRdData,
  input logic              irqReq,
  input logic              fiqReq
);
  logic quiet;
  assign quiet = !ctrlWrEn && !cntWrEn;

  AST_RESERVED_ZERO: assert property (@(posedge clk) disable iff (!rstN)
    (ctrlRdData & ~(WR_MASK & ~CLR_MASK)) == '0); // R2

  AST_DISABLED_HOLD: assert property (@(posedge clk) disable iff (!rstN)
    (quiet && !ctrlRdData[EN_BIT]) |=> $stable(cntRdData)); // R3

  AST_STEP_ONE: assert property (@(posedge clk) disable iff (!rstN)
    (quiet && tick && ctrlRdData[EN_BIT] && !ctrlRdData[DIV_BIT])
      |=> cntRdData == $past(cntRdData) + 1'b1); // R4

  AST_CLEAR_CMD: assert property (@(posedge clk) disable iff (!rstN)
    (ctrlWrEn && ctrlWrData[CLR_BIT] && !cntWrEn) |=> cntRdData == '0); // R6

  AST_WRAP_FLAG: assert property (@(posedge clk) disable iff (!rstN)
    (quiet && tick && ctrlRdData[EN_BIT] && !ctrlRdData[DIV_BIT] && (&cntRdData))
      |=> ctrlRdData[OVF_BIT]); // R8

  AST_ONE_LINE: assert property (@(posedge clk) disable iff (!rstN)
    !(irqReq && fiqReq)); // R10

  AST_LOAD_WINS: assert property (@(posedge clk) disable iff (!rstN)
    cntWrEn |=> cntRdData == $past(cntWrData)); // R11
endmodule

bind pmc_cycle_counter pmc_cycle_counter_chk #(.CNT_W(CNT_W)) chk_i (
  .clk(clk), .rstN(rstN), .tick(tick), .ctrlWrEn(ctrlWrEn),
  .ctrlWrData(ctrlWrData), .cntWrEn(cntWrEn), .cntWrData(cntWrData),
  .routeFast(routeFast), .ctrlRdData(ctrlRdData), .cntRdData(cntRdData),
  .irqReq(irqReq), .fiqReq(fiqReq)
);

// File: tb/pmc_cycle_counter_tb_top.sv
module pmc_cycle_counter_tb_top;
  localparam logic [31:0] EN = 32'h1, CLR = 32'h4, DIV = 32'h8;
  localparam logic [31:0] OVIE = 32'h40, OVF = 32'h400;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic tick = 1'b0, ctrlWrEn = 1'b0, cntWrEn = 1'b0, routeFast = 1'b0;
  logic [31:0] ctrlWrData = '0, cntWrData = '0;
  logic [31:0] ctrlRdData, cntRdData;
  logic irqReq, fiqReq;
  int checks = 0, fails = 0;
  bit done = 1'b0;

  always #5 clk = ~clk;

  pmc_cycle_counter dut_i (
    .clk(clk), .rstN(rstN), .tick(tick), .ctrlWrEn(ctrlWrEn),
    .ctrlWrData(ctrlWrData), .cntWrEn(cntWrEn), .cntWrData(cntWrData),
    .routeFast(routeFast), .ctrlRdData(ctrlRdData), .cntRdData(cntRdData),
    .irqReq(irqReq), .fiqReq(fiqReq)
  );

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wrCtrl(logic [31:0] v);
    ctrlWrEn = 1'b1; ctrlWrData = v;
    @(negedge clk);
    ctrlWrEn = 1'b0; ctrlWrData = '0;
  endtask

  task automatic wrCnt(logic [31:0] v);
    cntWrEn = 1'b1; cntWrData = v;
    @(negedge clk);
    cntWrEn = 1'b0; cntWrData = '0;
  endtask

  task automatic ticks(int n);
    tick = 1'b1;
    repeat (n) @(negedge clk);
    tick = 1'b0;
  endtask

  initial begin
    logic [31:0] held;
    int model;
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    // R1 reset state
    chk("R1 ctrl", ctrlRdData, 32'h0);
    chk("R1 cnt", cntRdData, 32'h0);
    chk("R1 irq", {30'h0, irqReq, fiqReq}, 32'h0);

    // R2 write mask
    wrCtrl(32'hFFFF_FFFF);
    chk("R2 mask", ctrlRdData, 32'h0FFF_F07B);
    wrCtrl(32'h0);
    chk("R2 zero", ctrlRdData, 32'h0);

    // R4 undivided counting over a gapped tick pattern
    wrCtrl(EN | CLR);
    model = 0;
    for (int i = 0; i < 60; i++) begin
      tick = (i % 3 != 1);
      @(negedge clk);
      if (i % 3 != 1) model++;
      chk("R4 count", cntRdData, model);
    end
    tick = 1'b0;

    // R3 disabled holds
    wrCtrl(32'h0);
    held = cntRdData;
    ticks(20);
    chk("R3 hold", cntRdData, held);

    // R6 clear command
    wrCtrl(EN | CLR);
    chk("R6 cleared", cntRdData, 32'h0);
    chk("R6 bit2", ctrlRdData & CLR, 32'h0);

    // R5 divided, back to back ticks
    wrCtrl(EN | DIV | CLR);
    for (int i = 1; i <= 200; i++) begin
      ticks(1);
      chk("R5 dense", cntRdData, i / 64);
    end
    // R5 divided, spaced ticks
    wrCtrl(EN | DIV | CLR);
    for (int i = 1; i <= 130; i++) begin
      ticks(1);
      @(negedge clk);
      chk("R5 sparse", cntRdData, i / 64);
    end

    // R7 prescaler cleared by clear command
    wrCtrl(EN | DIV | CLR);
    ticks(40);
    wrCtrl(EN | DIV | CLR);
    ticks(63);
    chk("R7 clr 63", cntRdData, 0);
    ticks(1);
    chk("R7 clr 64", cntRdData, 1);
    // R7 prescaler cleared by disable
    ticks(40);
    wrCtrl(DIV);
    wrCtrl(EN | DIV);
    ticks(63);
    chk("R7 dis 63", cntRdData, 1);
    ticks(1);
    chk("R7 dis 64", cntRdData, 2);
    // R7 prescaler cleared by divide change
    ticks(40);
    wrCtrl(EN);
    wrCtrl(EN | DIV);
    ticks(63);
    chk("R7 div 63", cntRdData, 2);
    ticks(1);
    chk("R7 div 64", cntRdData, 3);

    // R8 wrap and flag, R10 steering
    wrCtrl(EN | OVIE);
    wrCnt(32'hFFFF_FFFE);
    ticks(1);
    chk("R8 top", cntRdData, 32'hFFFF_FFFF);
    chk("R8 no flag", ctrlRdData & OVF, 32'h0);
    ticks(1);
    chk("R8 wrapped", cntRdData, 32'h0);
    chk("R8 flag", ctrlRdData & OVF, OVF);
    chk("R10 normal", {30'h0, irqReq, fiqReq}, 32'h2);
    repeat (5) @(negedge clk);
    chk("R10 level", {30'h0, irqReq, fiqReq}, 32'h2);
    routeFast = 1'b1; #1;
    chk("R10 fast", {30'h0, irqReq, fiqReq}, 32'h1);

    // R9 write-one-to-clear
    wrCtrl(EN | OVIE);
    chk("R9 kept", ctrlRdData & OVF, OVF);
    wrCtrl(EN | OVIE | OVF);
    chk("R9 cleared", ctrlRdData & OVF, 32'h0);
    chk("R10 released", {30'h0, irqReq, fiqReq}, 32'h0);
    // R9 wrap in the same cycle as a clearing write
    wrCnt(32'hFFFF_FFFF);
    tick = 1'b1; ctrlWrEn = 1'b1; ctrlWrData = EN | OVIE | OVF;
    @(negedge clk);
    tick = 1'b0; ctrlWrEn = 1'b0; ctrlWrData = '0;
    chk("R9 set wins", ctrlRdData & OVF, OVF);
    wrCtrl(EN | OVF);

    // R10 no request with interrupt enable clear
    wrCnt(32'hFFFF_FFFF);
    ticks(1);
    chk("R10 flag only", ctrlRdData & OVF, OVF);
    chk("R10 masked", {30'h0, irqReq, fiqReq}, 32'h0);

    // R11 count write beats an advance and a clear
    tick = 1'b1; cntWrEn = 1'b1; cntWrData = 32'h0000_1234;
    ctrlWrEn = 1'b1; ctrlWrData = EN | CLR;
    @(negedge clk);
    ctrlWrEn = 1'b0; ctrlWrData = '0; cntWrEn = 1'b0; cntWrData = '0;
    chk("R11 load", cntRdData, 32'h0000_1234);
    @(negedge clk);
    tick = 1'b0;
    chk("R11 resumes", cntRdData, 32'h0000_1235);

    if (!done) begin
      done = 1'b1;
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    #2000000;
    if (!done) begin
      done = 1'b1;
      fails++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end
endmodule